// File: doc/BRIEF.md
# Configuration Address/Data Port Bridge

This block sits on the host side of a configuration bus. It turns processor I/O reads and writes into configuration transactions. An eight-port I/O window is split into two parts. Offset 0 holds a 32-bit address register that selects a target. Offsets 4 to 7 form a data window, and each access to it goes to the selected target. The address register carries an enable flag, a bus number, a device/function number and a register offset.

When the enable flag is set and the bus number matches the local bus, a data-window access becomes a single-cycle request on the downstream port. The downstream side answers a read one cycle later with a found flag and right-justified data. In every other case the bridge settles the access itself. Writes are dropped. Reads return all-ones sized to the access.

The processor side is a valid/ready request stream paired with a valid/ready response stream. Only reads produce a response. A read response is held, with its data stable, until it is accepted. While a read is outstanding, `io_req_ready` stays low. Writes never lower ready, so writes can be accepted on consecutive cycles.

Top module: `cfg_port_bridge`

## Requirements
- R1: After reset the address register is zero, `io_req_ready` is 1, and both `io_rsp_valid` and `cfg_req_valid` are 0.
- R2: A 32-bit write (`io_req_size`=2) at port offset 0 loads all 32 bits into the address register. A 32-bit read at offset 0 returns the last value written, reserved bits included.
- R3: At port offsets 1 to 3, and for 8- or 16-bit accesses at offset 0, writes leave the address register unchanged and reads return all-ones of the access size.
- R4: While address bit 31 is 0, data-window accesses (offsets 4 to 7) issue no downstream request, and reads return all-ones of the access size.
- R5: A downstream request carries the bus number from address bits 23:16, the device/function from bits 15:8, the access size, and the write data masked to the access size.
- R6: For 32-bit data-window accesses the request offset is address bits 7:2 followed by two zero bits, whichever window port is used.
- R7: For 8-bit (size 0) and 16-bit (size 1) accesses, the request offset is address bits 7:0 ORed with the low two bits of the port offset. Size code 3 is never driven.
- R8: When address bits 23:16 differ from parameter `LOCAL_BUS` (default 0), no request is issued and reads return all-ones of the access size.
- R9: When a downstream read answers with found=0, the read returns all-ones of the access size. When found=1, it returns the downstream data masked to the access size, with the upper bits zero.
- R10: A downstream request is driven combinationally in the cycle the processor request is accepted. A read response becomes valid two cycles after acceptance. Writes produce no response.
- R11: While a read response is pending, `io_req_ready` is 0. While `io_rsp_ready` is 0, the response stays valid with stable data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_req_valid | input | 1 | Processor request valid |
| io_req_ready | output | 1 | Bridge can accept a request |
| io_req_write | input | 1 | 1 = write, 0 = read |
| io_req_port | input | 3 | Port offset in the window: 0 is the address register, 4 to 7 are the data window |
| io_req_size | input | 2 | 0 = 8-bit, 1 = 16-bit, 2 = 32-bit |
| io_req_wdata | input | 32 | Write data, right-justified |
| io_rsp_valid | output | 1 | Read response valid |
| io_rsp_ready | input | 1 | Processor accepts the response |
| io_rsp_rdata | output | 32 | Read data, right-justified |
| cfg_req_valid | output | 1 | Downstream request strobe |
| cfg_req_write | output | 1 | Downstream request is a write |
| cfg_req_bus | output | 8 | Target bus number |
| cfg_req_devfn | output | 8 | Target device/function |
| cfg_req_offset | output | 8 | Target register offset |
| cfg_req_size | output | 2 | Access size code |
| cfg_req_wdata | output | 32 | Write data masked to size |
| cfg_rsp_found | input | 1 | Target exists (valid the cycle after a read request) |
| cfg_rsp_rdata | input | 32 | Target read data (valid the cycle after a read request) |

## Verification
The assertions take two things for granted about the inputs. First, the processor never presents size code 3. Second, the downstream found flag and read data are valid exactly one cycle after a read request. The bench's downstream model answers on the clock edge that follows each read request, and returns deliberately wrong data when it reports not-found. Every stimulus vector and directed test uses only sizes 0, 1 and 2.

// File: rtl/cfg_bridge_pkg.sv
package cfg_bridge_pkg;

  localparam int ADDR_W   = 32;
  localparam int FIELD_W  = 8;
  localparam int PORT_W   = 3;
  localparam int SIZE_W   = 2;
  localparam int EN_POS   = ADDR_W - 1;
  localparam int BUS_LSB  = 2 * FIELD_W;
  localparam int DFN_LSB  = FIELD_W;
  localparam int TGT_W    = 3 * FIELD_W;

  typedef enum logic [1:0] {
    SRC_ADDR = 2'd0,
    SRC_ONES = 2'd1,
    SRC_DOWN = 2'd2
  } rsp_src_e;

  function automatic logic [ADDR_W-1:0] size_ones(input logic [SIZE_W-1:0] sz);
    if (sz[1])      return {ADDR_W{1'b1}};
    else if (sz[0]) return {{(ADDR_W-16){1'b0}}, 16'hFFFF};
    else            return {{(ADDR_W-8){1'b0}}, 8'hFF};
  endfunction

endpackage

// File: rtl/cfg_addr_reg.sv
module cfg_addr_reg
  import cfg_bridge_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wdata,
  output logic [ADDR_W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (wr_en) q <= wdata;
  end

endmodule

// File: rtl/cfg_route.sv
module cfg_route
  import cfg_bridge_pkg::*;
#(
  parameter logic [FIELD_W-1:0] LOCAL_BUS = '0
)(
  input  logic               accept,
  input  logic               wr,
  input  logic [PORT_W-1:0]  port,
  input  logic [SIZE_W-1:0]  size,
  input  logic [ADDR_W-1:0]  wdata,
  input  logic               cfg_en,
  input  logic [TGT_W-1:0]   target,
  output logic               addr_wr_en,
  output logic               req_valid,
  output logic [FIELD_W-1:0] req_bus,
  output logic [FIELD_W-1:0] req_devfn,
  output logic [FIELD_W-1:0] req_offset,
  output logic [ADDR_W-1:0]  req_wdata,
  output rsp_src_e           src
);

  logic is_word, is_window, addr_hit, bus_ok, go;

  always_comb begin
    is_word    = size[1];
    is_window  = port[PORT_W-1];
    addr_hit   = !is_window && (port[1:0] == 2'b00) && is_word;
    req_bus    = target[BUS_LSB +: FIELD_W];
    req_devfn  = target[DFN_LSB +: FIELD_W];
    bus_ok     = (req_bus == LOCAL_BUS);
    go         = is_window && cfg_en && bus_ok;
    if (is_word) req_offset = {target[FIELD_W-1:2], 2'b00};
    else         req_offset = target[FIELD_W-1:0] | {{(FIELD_W-2){1'b0}}, port[1:0]};
    req_wdata  = wdata & size_ones(size);
    addr_wr_en = accept && wr && addr_hit;
    req_valid  = accept && go;
    if (addr_hit)  src = SRC_ADDR;
    else if (go)   src = SRC_DOWN;
    else           src = SRC_ONES;
  end

endmodule

// File: rtl/cfg_rsp_stage.sv
module cfg_rsp_stage
  import cfg_bridge_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  rsp_src_e          src,
  input  logic [SIZE_W-1:0] size,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic              down_found,
  input  logic [ADDR_W-1:0] down_rdata,
  input  logic              rsp_ready,
  output logic              busy,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_rdata
);

  logic              s1_valid;
  rsp_src_e          s1_src;
  logic [SIZE_W-1:0] s1_size;
  logic [ADDR_W-1:0] result;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_src   <= SRC_ONES;
      s1_size  <= '0;
    end else begin
      s1_valid <= capture;
      if (capture) begin
        s1_src  <= src;
        s1_size <= size;
      end
    end
  end

  always_comb begin
    case (s1_src)
      SRC_ADDR: result = addr_q;
      SRC_DOWN: result = down_found ? (down_rdata & size_ones(s1_size)) : size_ones(s1_size);
      default:  result = size_ones(s1_size);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (s1_valid) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= result;
    end else if (rsp_valid && rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assign busy = s1_valid || rsp_valid;

  // R11: a stalled response keeps its valid and data
  p_rsp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));

endmodule

// File: rtl/cfg_port_bridge.sv
module cfg_port_bridge
  import cfg_bridge_pkg::*;
#(
  parameter logic [7:0] LOCAL_BUS = 8'h00
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        io_req_valid,
  output logic        io_req_ready,
  input  logic        io_req_write,
  input  logic [2:0]  io_req_port,
  input  logic [1:0]  io_req_size,
  input  logic [31:0] io_req_wdata,
  output logic        io_rsp_valid,
  input  logic        io_rsp_ready,
  output logic [31:0] io_rsp_rdata,
  output logic        cfg_req_valid,
  output logic        cfg_req_write,
  output logic [7:0]  cfg_req_bus,
  output logic [7:0]  cfg_req_devfn,
  output logic [7:0]  cfg_req_offset,
  output logic [1:0]  cfg_req_size,
  output logic [31:0] cfg_req_wdata,
  input  logic        cfg_rsp_found,
  input  logic [31:0] cfg_rsp_rdata
);

  logic              accept, addr_wr_en, busy;
  logic [ADDR_W-1:0] addr_q;
  rsp_src_e          src;

  assign io_req_ready  = !busy;
  assign accept        = io_req_valid && io_req_ready;
  assign cfg_req_write = io_req_write;
  assign cfg_req_size  = io_req_size;

  cfg_addr_reg u_addr (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (addr_wr_en),
    .wdata (io_req_wdata),
    .q     (addr_q)
  );

  cfg_route #(.LOCAL_BUS(LOCAL_BUS)) u_route (
    .accept     (accept),
    .wr         (io_req_write),
    .port       (io_req_port),
    .size       (io_req_size),
    .wdata      (io_req_wdata),
    .cfg_en     (addr_q[EN_POS]),
    .target     (addr_q[TGT_W-1:0]),
    .addr_wr_en (addr_wr_en),
    .req_valid  (cfg_req_valid),
    .req_bus    (cfg_req_bus),
    .req_devfn  (cfg_req_devfn),
    .req_offset (cfg_req_offset),
    .req_wdata  (cfg_req_wdata),
    .src        (src)
  );

  cfg_rsp_stage u_rsp (
    .clk        (clk),
    .rst_n      (rst_n),
    .capture    (accept && !io_req_write),
    .src        (src),
    .size       (io_req_size),
    .addr_q     (addr_q),
    .down_found (cfg_rsp_found),
    .down_rdata (cfg_rsp_rdata),
    .rsp_ready  (io_rsp_ready),
    .busy       (busy),
    .rsp_valid  (io_rsp_valid),
    .rsp_rdata  (io_rsp_rdata)
  );

  // R7: input assumption, size code 3 is never presented
  p_size_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    io_req_valid |-> io_req_size != 2'd3);

  // R3: the address register changes only on a 32-bit write at offset 0
  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept && io_req_write && io_req_port == 3'd0 && io_req_size == 2'd2)
      |=> $stable(addr_q));

  // R4: no downstream traffic while the enable flag is clear
  p_en_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req_valid |-> addr_q[EN_POS]);

  // R6: word requests are aligned
  p_word_align_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req_valid && cfg_req_size == 2'd2 |-> cfg_req_offset[1:0] == 2'b00);

  // R8: only the local bus is ever addressed
  p_local_bus_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req_valid |-> cfg_req_bus == LOCAL_BUS);

  // R10: a read is answered two cycles after acceptance
  p_read_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !io_req_write |=> !io_rsp_valid ##1 io_rsp_valid);

  // R11: no new request while a response waits
  p_ready_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    io_rsp_valid |-> !io_req_ready);

endmodule

// File: tb/cfg_port_bridge_tb.sv
module cfg_port_bridge_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_req_valid = 1'b0;
  logic        io_req_ready;
  logic        io_req_write = 1'b0;
  logic [2:0]  io_req_port = '0;
  logic [1:0]  io_req_size = '0;
  logic [31:0] io_req_wdata = '0;
  logic        io_rsp_valid;
  logic        io_rsp_ready = 1'b1;
  logic [31:0] io_rsp_rdata;
  logic        cfg_req_valid, cfg_req_write;
  logic [7:0]  cfg_req_bus, cfg_req_devfn, cfg_req_offset;
  logic [1:0]  cfg_req_size;
  logic [31:0] cfg_req_wdata;
  logic        cfg_rsp_found = 1'b0;
  logic [31:0] cfg_rsp_rdata = '0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  cfg_port_bridge dut_i (.*);

  function automatic logic [31:0] ones_of(input logic [1:0] sz);
    return sz == 2'd0 ? 32'hFF : sz == 2'd1 ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] model_data(input logic [7:0] dfn, input logic [7:0] off,
                                             input logic [1:0] sz);
    logic [31:0] v;
    for (int k = 0; k < 4; k++) v[k*8 +: 8] = (off + 8'(k)) ^ dfn;
    return v & ones_of(sz);
  endfunction

  // downstream model: functions present at devfn 0x00 and 0x08
  always @(posedge clk) begin
    if (cfg_req_valid && !cfg_req_write) begin
      cfg_rsp_found <= (cfg_req_devfn == 8'h00) || (cfg_req_devfn == 8'h08);
      cfg_rsp_rdata <= ((cfg_req_devfn == 8'h00) || (cfg_req_devfn == 8'h08))
                       ? model_data(cfg_req_devfn, cfg_req_offset, cfg_req_size)
                       : 32'h1234_5678;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic        wr;
    logic [2:0]  port;
    logic [1:0]  size;
    logic [31:0] wdata;
    logic        issue;
    logic [7:0]  devfn;
    logic [7:0]  off;
    logic [31:0] val;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 3'd0, 2'd2, 32'h7F00_0A55, 1'b0, 8'h00, 8'h00, 32'h0},          // R2 write, enable clear
    '{1'b0, 3'd0, 2'd2, 32'h0,         1'b0, 8'h00, 8'h00, 32'h7F00_0A55},  // R2 readback
    '{1'b0, 3'd4, 2'd0, 32'h0,         1'b0, 8'h00, 8'h00, 32'hFF},         // R4 read disabled
    '{1'b1, 3'd4, 2'd2, 32'hCAFE_F00D, 1'b0, 8'h00, 8'h00, 32'h0},          // R4 write dropped
    '{1'b0, 3'd0, 2'd1, 32'h0,         1'b0, 8'h00, 8'h00, 32'hFFFF},       // R3 half read of addr
    '{1'b1, 3'd0, 2'd0, 32'h12,        1'b0, 8'h00, 8'h00, 32'h0},          // R3 byte write ignored
    '{1'b1, 3'd1, 2'd2, 32'h0BAD_0BAD, 1'b0, 8'h00, 8'h00, 32'h0},          // R3 offset 1 ignored
    '{1'b0, 3'd2, 2'd2, 32'h0,         1'b0, 8'h00, 8'h00, 32'hFFFF_FFFF},  // R3 offset 2 read
    '{1'b0, 3'd0, 2'd2, 32'h0,         1'b0, 8'h00, 8'h00, 32'h7F00_0A55},  // R3 addr unchanged
    '{1'b1, 3'd0, 2'd2, 32'h8000_0811, 1'b0, 8'h00, 8'h00, 32'h0},          // R2 enable, devfn 8
    '{1'b0, 3'd4, 2'd2, 32'h0,         1'b1, 8'h08, 8'h10, 32'h1B1A_1918},  // R6 R9 word read
    '{1'b0, 3'd5, 2'd2, 32'h0,         1'b1, 8'h08, 8'h10, 32'h1B1A_1918},  // R6 forced alignment
    '{1'b0, 3'd6, 2'd0, 32'h0,         1'b1, 8'h08, 8'h13, 32'h1B},         // R7 byte merge
    '{1'b0, 3'd5, 2'd1, 32'h0,         1'b1, 8'h08, 8'h11, 32'h1A19},       // R7 half merge
    '{1'b1, 3'd7, 2'd0, 32'hABCD_EFAA, 1'b1, 8'h08, 8'h13, 32'hAA},         // R5 masked write
    '{1'b1, 3'd0, 2'd2, 32'h8001_0800, 1'b0, 8'h00, 8'h00, 32'h0},          // R8 bus 1
    '{1'b0, 3'd4, 2'd1, 32'h0,         1'b0, 8'h00, 8'h00, 32'hFFFF},       // R8 foreign bus
    '{1'b1, 3'd0, 2'd2, 32'h8000_2000, 1'b0, 8'h00, 8'h00, 32'h0},          // R9 absent devfn
    '{1'b0, 3'd7, 2'd0, 32'h0,         1'b1, 8'h20, 8'h03, 32'hFF}          // R9 not found
  };

  task automatic do_op(input logic wr, input logic [2:0] port, input logic [1:0] sz,
                       input logic [31:0] wd, output logic [31:0] rd, output logic issued,
                       output logic [7:0] dfn, output logic [7:0] off,
                       output logic [31:0] reqwd, output logic bus_ok, output logic lat_ok);
    @(negedge clk);
    while (!io_req_ready) @(negedge clk);
    io_req_valid = 1'b1; io_req_write = wr; io_req_port = port;
    io_req_size = sz; io_req_wdata = wd;
    #1;
    issued = cfg_req_valid; dfn = cfg_req_devfn; off = cfg_req_offset;
    reqwd = cfg_req_wdata; bus_ok = (cfg_req_bus == 8'h00) && (cfg_req_write == wr)
                                    && (cfg_req_size == sz);
    @(posedge clk);
    @(negedge clk);
    io_req_valid = 1'b0;
    lat_ok = !io_rsp_valid;
    @(negedge clk);
    lat_ok = lat_ok && (io_rsp_valid == !wr);
    rd = io_rsp_rdata;
  endtask

  initial begin
    logic [31:0] rd, reqwd;
    logic issued, bus_ok, lat_ok;
    logic [7:0] dfn, off;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(io_req_ready == 1'b1, "R1 ready", 32'(io_req_ready), 32'h1);
    check(io_rsp_valid == 1'b0, "R1 rsp_valid", 32'(io_rsp_valid), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(cfg_req_valid == 1'b0, "R1 cfg_req_valid", 32'(cfg_req_valid), 32'h0);
    do_op(1'b0, 3'd0, 2'd2, 32'h0, rd, issued, dfn, off, reqwd, bus_ok, lat_ok);
    check(rd == 32'h0, "R1 addr reset value", rd, 32'h0);

    foreach (VECS[i]) begin
      do_op(VECS[i].wr, VECS[i].port, VECS[i].size, VECS[i].wdata,
            rd, issued, dfn, off, reqwd, bus_ok, lat_ok);
      check(issued == VECS[i].issue, $sformatf("R4/R8 vec%0d issue", i),
            32'(issued), 32'(VECS[i].issue));
      check(lat_ok, $sformatf("R10 vec%0d response timing", i), 32'(lat_ok), 32'h1);
      if (VECS[i].issue) begin
        check(bus_ok, $sformatf("R5 vec%0d bus/write/size", i), 32'(bus_ok), 32'h1);
        check(dfn == VECS[i].devfn, $sformatf("R5 vec%0d devfn", i), 32'(dfn), 32'(VECS[i].devfn));
        check(off == VECS[i].off, $sformatf("R6/R7 vec%0d offset", i), 32'(off), 32'(VECS[i].off));
        if (VECS[i].wr)
          check(reqwd == VECS[i].val, $sformatf("R5 vec%0d wdata", i), reqwd, VECS[i].val);
      end
      if (!VECS[i].wr)
        check(rd == VECS[i].val, $sformatf("R2/R9 vec%0d rdata", i), rd, VECS[i].val);
    end

    // R11 back-pressure on the response
    do_op(1'b1, 3'd0, 2'd2, 32'h8000_0004, rd, issued, dfn, off, reqwd, bus_ok, lat_ok);
    @(negedge clk);
    io_rsp_ready = 1'b0;
    io_req_valid = 1'b1; io_req_write = 1'b0; io_req_port = 3'd4; io_req_size = 2'd2;
    @(posedge clk);
    @(negedge clk);
    io_req_valid = 1'b0;
    check(io_req_ready == 1'b0, "R11 ready low while pending", 32'(io_req_ready), 32'h0);
    @(negedge clk);
    for (int n = 0; n < 3; n++) begin
      check(io_rsp_valid == 1'b1, "R11 held valid", 32'(io_rsp_valid), 32'h1);
      check(io_rsp_rdata == 32'h0706_0504, "R11 held data", io_rsp_rdata, 32'h0706_0504);
      check(io_req_ready == 1'b0, "R11 ready low", 32'(io_req_ready), 32'h0);
      @(negedge clk);
    end
    io_rsp_ready = 1'b1;
    @(negedge clk);
    check(io_rsp_valid == 1'b0, "R11 released", 32'(io_rsp_valid), 32'h0);
    check(io_req_ready == 1'b1, "R11 ready back", 32'(io_req_ready), 32'h1);

    // R10 writes accepted on consecutive cycles
    io_req_valid = 1'b1; io_req_write = 1'b1; io_req_port = 3'd4; io_req_size = 2'd2;
    #1;
    check(cfg_req_valid == 1'b1, "R10 write strobe 1", 32'(cfg_req_valid), 32'h1);
    @(negedge clk);
    check(io_req_ready == 1'b1 && cfg_req_valid == 1'b1, "R10 write strobe 2",
          32'(cfg_req_valid), 32'h1);
    io_req_valid = 1'b0;
    @(negedge clk);
    check(io_rsp_valid == 1'b0, "R10 no write response", 32'(io_rsp_valid), 32'h0);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected<=20000", cycles);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule